// File: doc/BRIEF.md
# Receive FIFO Cut-Through Release Controller

This block runs alongside a multi-port receive packet FIFO. For every port it decides when the packet now being written may start to drain toward the system-side packet interface. The FIFO reports each stored 8-byte word through a valid strobe, with start-of-packet and end-of-packet markers. The block counts the stored words of the current packet. It compares that count with a per-port threshold that software can program.

A packet whose word count reaches the threshold while its end has not yet been written is released early. This is cut-through. A packet that ends at or below the threshold is released when its final word is written. This is store-and-forward. With the reset threshold of 190 words (1520 bytes), ordinary frames always use store-and-forward, and only longer frames can cut through.

The threshold register accepts a value only inside the legal window. The floor is 190 words. The ceiling is one below the FIFO high watermark for that port. An out-of-range write is clamped and sets a sticky error flag for that port.

Top module: `ct_release_ctrl`

## Requirements
- R1: After reset, every port's threshold reads back as 0x0000_00BE, every error flag is 0, and no release pulse is active.
- R2: A write to a port stores bits 11:0 of the write data when that value is legal, and ignores bits 31:12. Reading the port one cycle after `cfg_port` is set returns the threshold in bits 11:0 and zeros in bits 31:12.
- R3: A write whose 12-bit value is below 0x0BE stores 0x0BE and sets that port's sticky error flag. This check takes precedence over R4. The flag stays set until reset.
- R4: A write whose 12-bit value is at or above that port's high watermark `hwm` stores `hwm - 1` and sets the same sticky error flag.
- R5: If the word that brings a packet's count to the threshold is not an end-of-packet word, then `rel_pulse` is high for exactly one cycle in the cycle after that word, with `rel_cut` = 1 (cut-through). The start-of-packet word counts as word 1.
- R6: A packet whose total length is below the threshold produces one `rel_pulse` with `rel_cut` = 0 in the cycle after its end-of-packet word.
- R7: An end-of-packet word that brings the count exactly to the threshold gives a store-and-forward release (`rel_cut` = 0), not a cut-through release.
- R8: Each packet produces exactly one release pulse. After a cut-through release, the end-of-packet word produces no further pulse.
- R9: Each packet uses the threshold latched at its start-of-packet. A write made while a packet is in progress takes effect only from the next packet.
- R10: Ports are independent. A write or traffic on one port does not change another port's threshold, error flag or release pulses.
- R11: A valid word that arrives while the port is not inside a packet and carries no start-of-packet is ignored: it produces no pulse and adds nothing to the next packet's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_port | input | PIDX_W | Port selected for write and readback |
| cfg_wdata | input | 32 | Write data; bits 11:0 are the threshold in 8-byte words |
| cfg_rdata | output | 32 | Registered readback of the selected port's threshold |
| cfg_err | output | NUM_PORTS | Sticky illegal-programming flag, one per port |
| hwm | input | NUM_PORTS*THR_W | FIFO high watermark per port, in words; port p uses slice p |
| wr_valid | input | NUM_PORTS | One 8-byte word stored this cycle |
| wr_sop | input | NUM_PORTS | The stored word starts a packet |
| wr_eop | input | NUM_PORTS | The stored word ends a packet |
| rel_pulse | output | NUM_PORTS | One-cycle release of the current packet |
| rel_cut | output | NUM_PORTS | Qualifies `rel_pulse`: 1 = cut-through, 0 = store-and-forward |

## Verification
The bench sends packets just under the threshold, exactly at it, and just over it. A compare that is off by one would release a 190-word packet as cut-through, or release a 191-word packet at its end instead of at word 190. It checks that the end-of-packet of a packet already cut through stays silent, because a design that forgets the cut-through would pulse twice. It also rewrites the threshold in the middle of a packet: a design that does not latch the threshold at start-of-packet would release at the new point. Last, it drives clamp writes below the floor and above the watermark, and stray words outside any packet. These catch a wrong clamp value, a flag that sets on the wrong port, and stray counting that shifts the next release.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CFG_W   = 32;
  localparam int MIN_THR = 190;
  typedef enum logic {REL_STORE = 1'b0, REL_CUT = 1'b1} rel_kind_e;
endpackage

// File: rtl/ct_thr_reg.sv
module ct_thr_reg #(
  parameter int THR_W   = 12,
  parameter int MIN_THR = ct_pkg::MIN_THR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [THR_W-1:0] wdata,
  input  logic [THR_W-1:0] hwm,
  output logic [THR_W-1:0] thr_q,
  output logic             err_q
);
  localparam logic [THR_W-1:0] MIN_V = THR_W'(MIN_THR);

  logic             too_low, too_high;
  logic [THR_W-1:0] thr_nxt;

  always_comb begin
    too_low  = wdata < MIN_V;
    too_high = wdata >= hwm;
    if (too_low)       thr_nxt = MIN_V;
    else if (too_high) thr_nxt = hwm - 1'b1;
    else               thr_nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= MIN_V;
      err_q <= 1'b0;
    end else if (wr_en) begin
      thr_q <= thr_nxt;
      if (too_low || too_high) err_q <= 1'b1;
    end
  end

  // R3: a low write lands on the floor and raises the flag
  a_r3_floor_clamp: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wdata < MIN_V) |=> (thr_q == MIN_V) && err_q);
  // R3: the flag is sticky
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R4: a write at or over the watermark lands one below it
  a_r4_hwm_clamp: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wdata >= MIN_V) && (wdata >= hwm) |=> (thr_q == $past(hwm) - 1'b1) && err_q);
endmodule

// File: rtl/ct_pkt_track.sv
module ct_pkt_track #(
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             sop,
  input  logic             eop,
  input  logic [THR_W-1:0] thr,
  output logic             rel_q,
  output logic             cut_q
);
  import ct_pkg::*;
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  logic [THR_W-1:0] cnt_q, thr_act_q, base, t_use;
  logic             in_pkt_q, done_q, accept, dn, hit;

  always_comb begin
    accept = valid && (sop || in_pkt_q);
    base   = sop ? THR_W'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);
    t_use  = sop ? thr : thr_act_q;
    dn     = sop ? 1'b0 : done_q;
    hit    = base >= t_use;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      thr_act_q <= '0;
      in_pkt_q  <= 1'b0;
      done_q    <= 1'b0;
      rel_q     <= 1'b0;
      cut_q     <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      cut_q <= REL_STORE;
      if (accept) begin
        cnt_q     <= base;
        thr_act_q <= t_use;
        if (eop) begin
          in_pkt_q <= 1'b0;
          done_q   <= 1'b0;
          if (!dn) rel_q <= 1'b1;
        end else begin
          in_pkt_q <= 1'b1;
          if (hit && !dn) begin
            rel_q  <= 1'b1;
            cut_q  <= REL_CUT;
            done_q <= 1'b1;
          end else begin
            done_q <= dn;
          end
        end
      end
    end
  end

  // R7: an accepted end word of an unreleased packet releases store-and-forward
  a_r7_eop_store: assert property (@(posedge clk) disable iff (rst)
    valid && eop && !sop && in_pkt_q && !done_q |=> rel_q && !cut_q);
  // R8: no second pulse once the packet was cut through
  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    valid && !sop && eop && done_q |=> !rel_q);
  // R11: stray words outside a packet do nothing
  a_r11_stray: assert property (@(posedge clk) disable iff (rst)
    valid && !sop && !in_pkt_q |=> !rel_q);
  // R5: cut flag only qualifies a pulse
  a_r5_cut_qual: assert property (@(posedge clk) disable iff (rst)
    cut_q |-> rel_q);
endmodule

// File: rtl/ct_release_ctrl.sv
module ct_release_ctrl #(
  parameter int NUM_PORTS = 2,
  parameter int THR_W     = 12,
  parameter int PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [PIDX_W-1:0]          cfg_port,
  input  logic [ct_pkg::CFG_W-1:0]   cfg_wdata,
  output logic [ct_pkg::CFG_W-1:0]   cfg_rdata,
  output logic [NUM_PORTS-1:0]       cfg_err,
  input  logic [NUM_PORTS*THR_W-1:0] hwm,
  input  logic [NUM_PORTS-1:0]       wr_valid,
  input  logic [NUM_PORTS-1:0]       wr_sop,
  input  logic [NUM_PORTS-1:0]       wr_eop,
  output logic [NUM_PORTS-1:0]       rel_pulse,
  output logic [NUM_PORTS-1:0]       rel_cut
);
  import ct_pkg::*;
  localparam int PAD_W = CFG_W - THR_W;

  logic [THR_W-1:0] thr [NUM_PORTS];
  logic [THR_W-1:0] rd_sel;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel_wr;
    assign sel_wr = cfg_wr && (cfg_port == PIDX_W'(p));

    ct_thr_reg #(.THR_W(THR_W)) u_thr (
      .clk   (clk),
      .rst   (rst),
      .wr_en (sel_wr),
      .wdata (cfg_wdata[THR_W-1:0]),
      .hwm   (hwm[p*THR_W +: THR_W]),
      .thr_q (thr[p]),
      .err_q (cfg_err[p])
    );

    ct_pkt_track #(.THR_W(THR_W)) u_trk (
      .clk   (clk),
      .rst   (rst),
      .valid (wr_valid[p]),
      .sop   (wr_sop[p]),
      .eop   (wr_eop[p]),
      .thr   (thr[p]),
      .rel_q (rel_pulse[p]),
      .cut_q (rel_cut[p])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (cfg_port == PIDX_W'(p)) rd_sel = thr[p];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= {{PAD_W{1'b0}}, rd_sel};
  end

  // R2: readback upper bits are always zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[CFG_W-1:THR_W] == '0);
endmodule

// File: tb/ct_release_ctrl_bench.sv
module ct_release_ctrl_bench;
  localparam int NP = 2;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [0:0]    cfg_port = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NP-1:0] cfg_err;
  logic [NP*TW-1:0] hwm;
  logic [NP-1:0] wr_valid = '0, wr_sop = '0, wr_eop = '0;
  logic [NP-1:0] rel_pulse, rel_cut;

  int n_chk = 0, n_bad = 0;
  int thr_m [NP];
  int hwm_m [NP];
  bit err_m [NP];

  always #2 clk = ~clk;

  ct_release_ctrl u_ct_release_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_port(cfg_port),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .hwm(hwm), .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .rel_pulse(rel_pulse), .rel_cut(rel_cut));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_wr(int p, logic [31:0] d);
    int v = int'(d[11:0]);
    if (v < 190) begin thr_m[p] = 190; err_m[p] = 1; end
    else if (v >= hwm_m[p]) begin thr_m[p] = hwm_m[p] - 1; err_m[p] = 1; end
    else thr_m[p] = v;
  endtask

  task automatic do_write(int p, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_port = 1'(p); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_wr(p, d);
  endtask

  task automatic read_check(string req, int p);
    @(negedge clk);
    cfg_port = 1'(p);
    @(negedge clk);
    check(req, int'(cfg_rdata), thr_m[p]);
    check(req, int'(cfg_err[p]), int'(err_m[p]));
  endtask

  // Sends an n-word packet on port p; optionally writes wval to port p at word wat.
  task automatic send_pkt(string req, int p, int n, int wat, logic [31:0] wval);
    int t = thr_m[p];
    int exp_i = (n <= t) ? n - 1 : t - 1;
    int exp_c = (n <= t) ? 0 : 1;
    int pulses = 0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(req, int'(rel_pulse[p]), (i - 1 == exp_i) ? 1 : 0);
        if (i - 1 == exp_i) check(req, int'(rel_cut[p]), exp_c);
        check("R10", int'(rel_pulse[1-p]), 0);
        pulses += int'(rel_pulse[p]);
      end
      wr_valid = '0; wr_sop = '0; wr_eop = '0; cfg_wr = 1'b0;
      if (i < n) begin
        wr_valid[p] = 1'b1;
        wr_sop[p]   = (i == 0);
        wr_eop[p]   = (i == n - 1);
        if (i == wat) begin
          cfg_wr = 1'b1; cfg_port = 1'(p); cfg_wdata = wval;
          model_wr(p, wval);
        end
      end
    end
    check("R8", pulses, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", int'(rel_pulse), 0);
    check("R1", int'(cfg_err), 0);
    read_check("R1", 0);
    read_check("R1", 1);
  endtask

  task automatic t_basic;
    send_pkt("R6", 0, 10, -1, 0);
    send_pkt("R7", 0, 190, -1, 0);
    send_pkt("R5", 0, 191, -1, 0);
    send_pkt("R8", 0, 250, -1, 0);
    send_pkt("R6", 1, 1, -1, 0);
  endtask

  task automatic t_program;
    do_write(0, 32'hFFF0_00C8);
    read_check("R2", 0);
    send_pkt("R5", 0, 230, -1, 0);
    do_write(0, 32'h0000_0005);
    read_check("R3", 0);
    read_check("R10", 1);
    do_write(0, 32'h0000_0100);
    read_check("R3", 0);
    do_write(0, 32'h0000_0FFF);
    read_check("R4", 0);
    send_pkt("R4", 0, 320, -1, 0);
  endtask

  task automatic t_midwrite;
    do_write(1, 32'd250);
    read_check("R2", 1);
    send_pkt("R9", 1, 300, 50, 32'd195);
    read_check("R9", 1);
    send_pkt("R9", 1, 300, -1, 0);
    read_check("R10", 0);
  endtask

  task automatic t_stray;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr_valid = 2'b10; wr_sop = '0; wr_eop = (i == 4) ? 2'b10 : 2'b00;
      @(negedge clk);
      wr_valid = '0; wr_eop = '0;
      check("R11", int'(rel_pulse[1]), 0);
    end
    // count restarts at start: 194 words stays store-and-forward under 195
    send_pkt("R11", 1, 194, -1, 0);
  endtask

  initial begin
    thr_m = '{190, 190}; err_m = '{0, 0}; hwm_m = '{300, 4000};
    hwm = {12'(hwm_m[1]), 12'(hwm_m[0])};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_program();
    t_midwrite();
    t_stray();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule